// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Host

This block is the host end of a bidirectional one-wire serial link. It reads and writes 8-bit registers in a peripheral. The wire is open-drain and shared. The host can only pull it low through `line_oe` and observes it on `line_in`. Every bit is a self-timed frame with three parts: a low start, a data window, and a return to high. A 0 is sent by keeping the line low through the data window. A 1 is sent by releasing the line after the short start pulse.

A transaction begins with a one-cycle `start` pulse, carrying a direction flag, a 7-bit register address and, for a write, a data byte. The host first sends a long low break pulse followed by a recovery high phase. It then sends the command byte. For a write it sends the data byte next. For a read it releases the wire and collects eight frames driven by the peripheral, sampling each one a fixed delay after its falling edge. The block reports completion with a one-cycle `done` pulse. If the peripheral stays silent too long, the block abandons the read and raises `err`.

All timing is given in clock cycles through parameters: break low, break recovery, short start, long low, bit cycle, receive sample delay and receive timeout.

Top module: `rto_wire_host`

## Requirements
- R1: After reset the wire is released (`line_oe`=0), `done`=0, `err`=0 and `rdata`=0.
- R2: Each accepted transaction begins with `line_oe` high for exactly T_BRK cycles. The next falling edge of the wire comes T_BRK+T_BRK_REC+1 cycles after the start of that break.
- R3: A host bit of value 1 holds `line_oe` high for T_START cycles. A bit of value 0 holds it for T_STOP cycles. Successive host bits start T_CYC+1 cycles apart.
- R4: The command byte carries the address in bits 6..0 and the direction in bit 7, where 1 means write and 0 means read. It is sent bit 0 first.
- R5: On a write, the eight data bits follow the command bit 0 first. Then `done` pulses with `err`=0.
- R6: On a read, each peripheral frame is sampled T_SAMP+1 cycles after its falling edge reaches the block. The bits are assembled bit 0 first, and the byte appears on `rdata` in the cycle `done` pulses.
- R7: If no falling edge arrives within T_TMO cycles while a read bit is awaited, `done` pulses with `err`=1, the block returns to idle and `rdata` keeps its old value. `err` is cleared when the next transaction is accepted.
- R8: From the end of the command byte until a read ends, the host never pulls the wire low. The host has no way to drive the wire high.
- R9: `done` is never high for two cycles in a row. `rdata` changes only in a cycle in which a read completes.
- R10: A `start` pulse that arrives while a transaction is in progress is ignored. No second break is sent, and the running command and data are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rw | input | 1 | Direction: 1 write, 0 read |
| addr | input | 7 | Register address |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte from the last successful read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction ended by receive timeout |
| line_oe | output | 1 | Enables the pull-down on the wire |
| line_in | input | 1 | Observed level of the wire |

## Verification
The hardest situation to reach from the ports is the hand-over of the wire in the middle of a read. The peripheral must begin driving only after the host has released the line, and it must then produce frames whose lows straddle the host's sample point. The bench therefore decodes the host's command from pulse widths on `line_oe`. Once it has seen eight command frames of a read, it waits one bit cycle and then drives its own frames through a behavioural pull-down. The same model is kept silent to force the timeout. A second `start` is also injected in the middle of a write to show that it has no effect on the wire.

// File: rtl/rto_pkg.sv
// Package: shared types for the return-to-one single-wire host.
// Assumes: one transaction in flight at a time.
package rto_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BRK  = 3'd1,
        ST_CMD  = 3'd2,
        ST_WR   = 3'd3,
        ST_RD   = 3'd4
    } host_st_t;

endpackage

// File: rtl/rto_bit_tx.sv
// Module: rto_bit_tx
// Generates one low-then-released frame on the wire enable. The frame is
// lo_len cycles of pull-down followed by release until tot_len cycles
// have elapsed. The same engine serves break pulses and data bits.
// Assumes: go is only raised while busy is low; lo_len < tot_len.
module rto_bit_tx #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] tot_len,
    output logic          line_oe,
    output logic          busy,
    output logic          fin
);

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lo_q;
    logic [CW-1:0] tot_q;

    // Frame counter: latch the lengths on go, count to the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            lo_q   <= '0;
            tot_q  <= '0;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                lo_q   <= lo_len;
                tot_q  <= tot_len;
            end
        end else if (cnt == tot_q - CW'(1)) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign line_oe = active && (cnt < lo_q);
    assign busy    = active;
    assign fin     = active && (cnt == tot_q - CW'(1));

endmodule

// File: rtl/rto_bit_rx.sv
// Module: rto_bit_rx
// Receives return-to-one frames from the peripheral. It registers the
// wire twice, finds a high-to-low change, waits T_SAMP cycles and
// reports the wire level as the bit. It flags a timeout when no falling
// edge arrives within T_TMO cycles of enable or of the previous sample.
// Assumes: line_in is already synchronous to clk; T_SAMP >= 1.
module rto_bit_rx #(
    parameter int T_SAMP = 10,
    parameter int T_TMO  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_in,
    output logic bit_vld,
    output logic bit_val,
    output logic tmo
);

    localparam int SW = $clog2(T_SAMP + 1);
    localparam int TW = $clog2(T_TMO + 1);

    logic          ln_q, ln_qq;
    logic          hold;
    logic [SW-1:0] scnt;
    logic [TW-1:0] tcnt;
    logic          fall;

    assign fall = ln_qq && !ln_q;

    // Wire history for edge detection, kept running at all times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q  <= 1'b1;
            ln_qq <= 1'b1;
        end else begin
            ln_q  <= line_in;
            ln_qq <= ln_q;
        end
    end

    // Edge-wait / sample-delay sequencer with silence counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold <= 1'b0;
            scnt <= '0;
            tcnt <= '0;
        end else if (hold) begin
            if (scnt == SW'(T_SAMP - 1)) begin
                hold <= 1'b0;
                tcnt <= '0;
            end else begin
                scnt <= scnt + SW'(1);
            end
        end else if (fall) begin
            hold <= 1'b1;
            scnt <= '0;
        end else if (tcnt != TW'(T_TMO - 1)) begin
            tcnt <= tcnt + TW'(1);
        end
    end

    assign bit_vld = en && hold && (scnt == SW'(T_SAMP - 1));
    assign bit_val = ln_q;
    assign tmo     = en && !hold && !fall && (tcnt == TW'(T_TMO - 1));

    // A sample window opens only on a high-to-low change of the wire (R6).
    p_open_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(hold)) |-> ($past(ln_qq) && !$past(ln_q)));

endmodule

// File: rtl/rto_wire_host.sv
// Module: rto_wire_host
// Host transaction sequencer for a single-wire return-to-one link.
// Sequence: break, command byte bit 0 first, then either write data
// bits or eight received frames. Ends with a one-cycle done pulse.
// Assumes: external open-drain pad with pull-up; line_in is synchronous.
module rto_wire_host
    import rto_pkg::*;
#(
    parameter int T_BRK     = 40,
    parameter int T_BRK_REC = 12,
    parameter int T_START   = 4,
    parameter int T_STOP    = 16,
    parameter int T_CYC     = 24,
    parameter int T_SAMP    = 10,
    parameter int T_TMO     = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic              line_oe,
    input  logic              line_in
);

    localparam int TOT_BRK = T_BRK + T_BRK_REC;
    localparam int LEN_MAX = (TOT_BRK > T_CYC) ? TOT_BRK : T_CYC;
    localparam int CW      = $clog2(LEN_MAX + 1);
    localparam int IW      = $clog2(BYTE_W);

    host_st_t          st;
    logic [IW-1:0]     idx;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] wd_q;
    logic [BYTE_W-1:0] rsh;

    logic              tx_go, tx_busy, tx_fin;
    logic [CW-1:0]     tx_lo, tx_tot;
    logic              cur_bit;
    logic              rx_en, rx_vld, rx_val, rx_tmo;

    // Pick the frame shape for the current phase and bit.
    always_comb begin
        cur_bit = (st == ST_CMD) ? cmd_q[idx] : wd_q[idx];
        if (st == ST_BRK) begin
            tx_lo  = CW'(T_BRK);
            tx_tot = CW'(TOT_BRK);
        end else begin
            tx_lo  = cur_bit ? CW'(T_START) : CW'(T_STOP);
            tx_tot = CW'(T_CYC);
        end
    end

    assign tx_go = ((st == ST_BRK) || (st == ST_CMD) || (st == ST_WR)) && !tx_busy;
    assign rx_en = (st == ST_RD);

    rto_bit_tx #(.CW(CW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (tx_go),
        .lo_len  (tx_lo),
        .tot_len (tx_tot),
        .line_oe (line_oe),
        .busy    (tx_busy),
        .fin     (tx_fin)
    );

    rto_bit_rx #(.T_SAMP(T_SAMP), .T_TMO(T_TMO)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .line_in (line_in),
        .bit_vld (rx_vld),
        .bit_val (rx_val),
        .tmo     (rx_tmo)
    );

    // Transaction state, bit index, shift registers and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            idx   <= '0;
            cmd_q <= '0;
            wd_q  <= '0;
            rsh   <= '0;
            rdata <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cmd_q <= {rw, addr};
                    wd_q  <= wdata;
                    err   <= 1'b0;
                    idx   <= '0;
                    st    <= ST_BRK;
                end
                ST_BRK: if (tx_fin) begin
                    idx <= '0;
                    st  <= ST_CMD;
                end
                ST_CMD: if (tx_fin) begin
                    idx <= idx + IW'(1);
                    if (idx == IW'(BYTE_W - 1))
                        st <= cmd_q[BYTE_W-1] ? ST_WR : ST_RD;
                end
                ST_WR: if (tx_fin) begin
                    idx <= idx + IW'(1);
                    if (idx == IW'(BYTE_W - 1)) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                ST_RD: begin
                    if (rx_vld) begin
                        rsh <= {rx_val, rsh[BYTE_W-1:1]};
                        idx <= idx + IW'(1);
                        if (idx == IW'(BYTE_W - 1)) begin
                            rdata <= {rx_val, rsh[BYTE_W-1:1]};
                            done  <= 1'b1;
                            st    <= ST_IDLE;
                        end
                    end else if (rx_tmo) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Idle host leaves the wire released (R1).
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !line_oe);

    // Host keeps off the wire while the peripheral talks (R8).
    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD) |-> !line_oe);

    // Completion strobe lasts one cycle (R9).
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Read data moves only with the completion of a read (R9).
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (done && !cmd_q[BYTE_W-1]));

    // Timeout error appears together with completion (R7).
    p_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // A running transaction keeps its command whatever start does (R10).
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(cmd_q));

endmodule

// File: tb/sim_rto_wire_host.sv
module sim_rto_wire_host;

    localparam int PB = 40;
    localparam int PR = 12;
    localparam int PS = 4;
    localparam int PP = 16;
    localparam int PC = 24;
    localparam int PM = 10;
    localparam int PT = 200;

    // Vector: {rw, addr[6:0], wdata[7:0], peripheral byte[7:0]}
    localparam int NV = 7;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {1'b1, 7'h01, 8'hA5, 8'h00},
        {1'b0, 7'h7F, 8'h00, 8'h3C},
        {1'b1, 7'h00, 8'h00, 8'h00},
        {1'b1, 7'h55, 8'hFF, 8'h00},
        {1'b0, 7'h2A, 8'h00, 8'h81},
        {1'b0, 7'h00, 8'h00, 8'h00},
        {1'b0, 7'h40, 8'h00, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rw = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       done, err, line_oe;
    logic       pull = 1'b0;
    logic       line_in;

    assign line_in = !(line_oe || pull);

    always #5 clk = !clk;

    rto_wire_host #(
        .T_BRK(PB), .T_BRK_REC(PR), .T_START(PS), .T_STOP(PP),
        .T_CYC(PC), .T_SAMP(PM), .T_TMO(PT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .err(err),
        .line_oe(line_oe), .line_in(line_in)
    );

    int n_chk = 0, n_bad = 0;
    int mon_chk = 0, mon_bad = 0;
    int dn_chk = 0, dn_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Wire monitor: decodes host frames from pull-down widths and spacing.
    int          cyc = 0, lo_w = 0, rise_t = 0, prev_rise = 0, prev_kind = 0;
    int          hcnt = 0, brk_cnt = 0;
    logic [15:0] hbits = '0;
    logic        oe_p = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (line_oe && !oe_p) begin
                rise_t = cyc;
                lo_w = 1;
            end else if (line_oe) begin
                lo_w++;
            end else if (oe_p) begin
                if (lo_w == PB) begin
                    mon_chk++;          // R2 break width
                    brk_cnt++;
                    hcnt = 0;
                    hbits = '0;
                    prev_kind = 1;
                    prev_rise = rise_t;
                end else if (lo_w == PS || lo_w == PP) begin
                    mon_chk++;
                    if (prev_kind == 1 && (rise_t - prev_rise) != PB + PR + 1) begin
                        mon_bad++;
                        $display("FAIL R2 break-to-bit gap act=%0d exp=%0d", rise_t - prev_rise, PB + PR + 1);
                    end else if (prev_kind == 2 && (rise_t - prev_rise) != PC + 1) begin
                        mon_bad++;
                        $display("FAIL R3 bit spacing act=%0d exp=%0d", rise_t - prev_rise, PC + 1);
                    end
                    if (hcnt < 16) hbits[hcnt[3:0]] = (lo_w == PS);
                    hcnt++;
                    prev_kind = 2;
                    prev_rise = rise_t;
                end else begin
                    mon_chk++;
                    mon_bad++;
                    $display("FAIL R3 low width act=%0d exp=%0d or %0d (or %0d for R2)", lo_w, PS, PP, PB);
                end
            end
            oe_p = line_oe;
        end else begin
            oe_p = 1'b0;
        end
    end

    // Completion tracker: counts done pulses and captures outputs there.
    int         dn_cnt = 0;
    logic       dn_err = 1'b0;
    logic [7:0] dn_rd = '0;
    logic       done_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                dn_cnt++;
                dn_err = err;
                dn_rd = rdata;
                dn_chk++;
                if (done_p) begin
                    dn_bad++;
                    $display("FAIL R9 done width act=2 exp=1");
                end
            end
            done_p = done;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk + mon_chk + dn_chk + 1, n_bad + mon_bad + dn_bad + 1);
        $finish;
    end

    task automatic run_txn(input logic rw_i, input logic [6:0] a_i, input logic [7:0] w_i,
                           input logic [7:0] p_i, input bit silent, output int d0);
        int b0;
        int lim;
        d0 = dn_cnt;
        b0 = brk_cnt;
        @(negedge clk);
        start = 1'b1; rw = rw_i; addr = a_i; wdata = w_i;
        @(negedge clk);
        start = 1'b0;
        if (!rw_i) begin
            lim = 0;
            while (!(brk_cnt == b0 + 1 && hcnt == 8) && lim < 5000) begin
                @(negedge clk);
                lim++;
            end
            repeat (PC) @(negedge clk);
            if (!silent) begin
                for (int i = 0; i < 8; i++) begin
                    pull = 1'b1;
                    repeat (p_i[i] ? PS : PP) @(negedge clk);
                    pull = 1'b0;
                    repeat (PC - (p_i[i] ? PS : PP)) @(negedge clk);
                end
            end
        end
        lim = 0;
        while (dn_cnt == d0 && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [7:0] last_rd;
        int d0;
        int b0;
        last_rd = '0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(line_oe == 1'b0, "R1 line_oe", line_oe, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            run_txn(e[23], e[22:16], e[15:8], e[7:0], 1'b0, d0);
            chk(dn_cnt == d0 + 1, "R9 one done per transaction", dn_cnt - d0, 1);
            chk(hbits[7:0] == e[23:16], "R4 command byte", hbits[7:0], e[23:16]);
            chk(dn_err == 1'b0, "R5/R6 err on success", dn_err, 0);
            if (e[23]) begin
                chk(hcnt == 16, "R5 host bit count", hcnt, 16);
                chk(hbits[15:8] == e[15:8], "R5 write byte", hbits[15:8], e[15:8]);
                chk(rdata == last_rd, "R9 rdata kept over write", rdata, last_rd);
            end else begin
                chk(hcnt == 8, "R8 host silent during read", hcnt, 8);
                chk(dn_rd == e[7:0], "R6 read byte", dn_rd, e[7:0]);
                last_rd = e[7:0];
            end
        end

        // R7: silent peripheral forces a timeout
        run_txn(1'b0, 7'h11, 8'h00, 8'h00, 1'b1, d0);
        chk(dn_cnt == d0 + 1, "R7 done on timeout", dn_cnt - d0, 1);
        chk(dn_err == 1'b1, "R7 err on timeout", dn_err, 1);
        chk(rdata == last_rd, "R7 rdata kept on timeout", rdata, last_rd);
        chk(hcnt == 8, "R8 no host pull after read command", hcnt, 8);

        // R7: next transaction clears err
        run_txn(1'b1, 7'h22, 8'h96, 8'h00, 1'b0, d0);
        chk(dn_err == 1'b0, "R7 err cleared by next start", dn_err, 0);
        chk(hbits[15:8] == 8'h96, "R5 write byte after timeout", hbits[15:8], 8'h96);

        // R10: second start in the middle of a write
        d0 = dn_cnt;
        b0 = brk_cnt;
        @(negedge clk);
        start = 1'b1; rw = 1'b1; addr = 7'h33; wdata = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        repeat (150) @(negedge clk);
        start = 1'b1; rw = 1'b0; addr = 7'h7E; wdata = 8'hC3;
        @(negedge clk);
        start = 1'b0;
        repeat (600) @(negedge clk);
        chk(brk_cnt == b0 + 1, "R10 single break", brk_cnt - b0, 1);
        chk(hbits[7:0] == 8'hB3, "R10 command kept", hbits[7:0], 8'hB3);
        chk(hbits[15:8] == 8'h5A, "R10 data kept", hbits[15:8], 8'h5A);
        chk(dn_cnt == d0 + 1, "R10 single done", dn_cnt - d0, 1);
        chk(line_oe == 1'b0, "R10 wire released afterwards", line_oe, 0);

        $display("  test done: total=%0d bad=%0d", n_chk + mon_chk + dn_chk, n_bad + mon_bad + dn_bad);
        $finish;
    end

endmodule